// File: doc/BRIEF.md
# Banked Register File Address Mapper

This block turns the 5-bit register operand of an instruction into a location in a physical register file of up to four banks. The 32-entry operand window is split in two. Its lower sixteen entries reach one common region that every bank shares. Its upper sixteen entries reach a bank that is picked by two bits of an internal pointer register. Operand zero is not a storage location. It is a redirect: the access goes to the location named by the pointer register, whose bits 6..5 give the bank and whose bits 4..0 give the window entry.

Besides the mapping, the block holds the pointer register and the general-purpose storage. That storage is the eight common bytes above the special-function area, plus sixteen bytes for each implemented bank. The other special-function locations are only flagged for the surrounding core: they read as zero here and ignore writes. A read issued in one cycle returns its data, with a valid strobe, in the next cycle. The physical address and the class flags are combinational from the current operand and the current pointer.

Top module: `regfile_bank_mapper`

## Requirements
- R1: An operand from 0x01 to 0x0F maps to physical address {3'b000, operand[3:0]}, whatever the pointer's bank bits hold.
- R2: An operand from 0x10 to 0x1F maps to physical address {ptr[6:5], 1'b1, operand[3:0]}, so the same operand reaches different storage in each bank.
- R3: Operand 0x00 with ptr[4:0] nonzero accesses window entry ptr[4:0] in bank ptr[6:5], mapped as in R1 and R2. Pointer bit 7 has no effect on the mapping.
- R4: Operand 0x00 with ptr[4:0] equal to zero is a null access. isNull is 1, physAddr is 0x00, a read returns 0x00, and a write changes neither the pointer nor any storage.
- R5: isSfr is 1 exactly when the resolved window entry is 0x00 to 0x07. isRam is 1 exactly when the entry is 0x08 to 0x1F and, for entries 0x10 to 0x1F, the bank is below NUM_BANKS. The two flags are never both 1.
- R6: A byte written to a RAM location is returned by a later read of that location. Read data and rdValid=1 appear in the cycle after the cycle in which rdEn is high. rdValid is 0 in the cycle after any cycle without rdEn.
- R7: The pointer register sits at window entry 0x04. It can be written and read there, either directly or through operand 0x00, and it resets to 0x00.
- R8: Special-function entries other than 0x04 read as 0x00, and a write to them changes nothing.
- R9: A banked entry in a bank at or above NUM_BANKS has isRam=0, reads as 0x00, and ignores writes.
- R10: When a read and a write hit the same location in the same cycle, the read returns the value held before that write.
- R11: After reset, rdValid is 0 and every RAM location reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| directAddr | input | 5 | Register operand from the instruction |
| rdEn | input | 1 | Read strobe |
| wrEn | input | 1 | Write strobe |
| wrData | input | DATA_W | Write data |
| physAddr | output | 7 | Resolved physical register address |
| isSfr | output | 1 | Resolved entry is a special-function location |
| isRam | output | 1 | Resolved entry is implemented general-purpose RAM |
| isNull | output | 1 | Redirect through a pointer that names operand zero |
| rdValid | output | 1 | Read data valid, one cycle after rdEn |
| rdData | output | DATA_W | Read data |

## Verification
The bench builds the block with NUM_BANKS=3 and DATA_W=8. With three banks, bank 3 exists in the pointer's encoding but has no storage behind it. This lets the bench reach the unimplemented-bank case both by direct operands and through redirects. Within the same run it also fills and reads back every implemented bank, shows the common-region aliasing across banks, and exercises the null redirect, pointer bit 7, and a read and write to the same location in one cycle.

// File: rtl/regmap_pkg.sv
package regmap_pkg;
  localparam int WIN_W  = 5;
  localparam int BANK_W = 2;
  localparam int PHYS_W = BANK_W + WIN_W;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_FSR  = 2'd1,
    SRC_RAM  = 2'd2
  } rdSrc_e;

  typedef struct packed {
    logic   ramWe;
    logic   fsrWe;
    logic   rdReq;
    rdSrc_e rdSrc;
  } mapStrobes_t;
endpackage

// File: rtl/bank_addr_ctrl.sv
module bank_addr_ctrl
  import regmap_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic [WIN_W-1:0]  directAddr,
  input  logic [PHYS_W-1:0] fsrPtr,
  input  logic              rdEn,
  input  logic              wrEn,
  output logic [PHYS_W-1:0] physAddr,
  output logic              isSfr,
  output logic              isRam,
  output logic              isNull,
  output mapStrobes_t       strobes
);
  localparam logic [BANK_W:0] BANK_LIMIT = (BANK_W + 1)'(NUM_BANKS);
  localparam logic [WIN_W-1:0] FSR_ENTRY = WIN_W'(4);

  logic              useInd;
  logic [WIN_W-1:0]  winAddr;
  logic [BANK_W-1:0] bankSel;
  logic              banked;
  logic              bankOk;
  logic              isFsr;

  always_comb begin
    useInd  = (directAddr == '0);
    winAddr = useInd ? fsrPtr[WIN_W-1:0] : directAddr;
    bankSel = fsrPtr[PHYS_W-1:WIN_W];
    isNull  = useInd && (fsrPtr[WIN_W-1:0] == '0);
    banked  = winAddr[WIN_W-1];
    bankOk  = !banked || ({1'b0, bankSel} < BANK_LIMIT);
    if (banked) physAddr = {bankSel, 1'b1, winAddr[WIN_W-2:0]};
    else        physAddr = {{BANK_W{1'b0}}, 1'b0, winAddr[WIN_W-2:0]};
    isSfr = !banked && !winAddr[WIN_W-2];
    isRam = !isSfr && bankOk;
    isFsr = !isNull && (winAddr == FSR_ENTRY);

    strobes.ramWe = wrEn && isRam;
    strobes.fsrWe = wrEn && isFsr;
    strobes.rdReq = rdEn;
    if (isRam)      strobes.rdSrc = SRC_RAM;
    else if (isFsr) strobes.rdSrc = SRC_FSR;
    else            strobes.rdSrc = SRC_ZERO;
  end
endmodule

// File: rtl/regfile_datapath.sv
module regfile_datapath
  import regmap_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  mapStrobes_t       strobes,
  input  logic [PHYS_W-1:0] physAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [PHYS_W-1:0] fsrPtr,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  localparam int COMMON_GP = 8;
  localparam int BANK_SZ   = 16;
  localparam int RAM_DEPTH = COMMON_GP + BANK_SZ * NUM_BANKS;
  localparam int IDX_W     = $clog2(RAM_DEPTH);

  logic [DATA_W-1:0] fsrReg;
  logic [DATA_W-1:0] ramMem [RAM_DEPTH];
  logic [IDX_W-1:0]  ramIdx;
  logic [DATA_W-1:0] ramRd;

  always_comb begin
    int flat;
    if (physAddr[WIN_W-1])
      flat = COMMON_GP + BANK_SZ * int'(physAddr[PHYS_W-1:WIN_W]) + int'(physAddr[3:0]);
    else
      flat = int'(physAddr[2:0]);
    if (flat >= RAM_DEPTH) flat = 0;
    ramIdx = IDX_W'(flat);
    ramRd  = ramMem[ramIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_DEPTH; i++) ramMem[i] <= '0;
    end else if (strobes.ramWe) begin
      ramMem[ramIdx] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              fsrReg <= '0;
    else if (strobes.fsrWe) fsrReg <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobes.rdReq;
      if (!strobes.rdReq) rdData <= '0;
      else begin
        case (strobes.rdSrc)
          SRC_RAM: rdData <= ramRd;
          SRC_FSR: rdData <= fsrReg;
          default: rdData <= '0;
        endcase
      end
    end
  end

  assign fsrPtr = fsrReg[PHYS_W-1:0];
endmodule

// File: rtl/regfile_bank_mapper.sv
module regfile_bank_mapper
  import regmap_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int DATA_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [4:0]        directAddr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [6:0]        physAddr,
  output logic              isSfr,
  output logic              isRam,
  output logic              isNull,
  output logic              rdValid,
  output logic [DATA_W-1:0] rdData
);
  mapStrobes_t       strobes;
  logic [PHYS_W-1:0] fsrPtr;

  bank_addr_ctrl #(.NUM_BANKS(NUM_BANKS)) ctrl_i (
    .directAddr(directAddr),
    .fsrPtr    (fsrPtr),
    .rdEn      (rdEn),
    .wrEn      (wrEn),
    .physAddr  (physAddr),
    .isSfr     (isSfr),
    .isRam     (isRam),
    .isNull    (isNull),
    .strobes   (strobes)
  );

  regfile_datapath #(.NUM_BANKS(NUM_BANKS), .DATA_W(DATA_W)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .physAddr(physAddr),
    .wrData  (wrData),
    .fsrPtr  (fsrPtr),
    .rdValid (rdValid),
    .rdData  (rdData)
  );
endmodule

// File: rtl/regmap_checker.sv
module regmap_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [4:0]        directAddr,
  input logic              rdEn,
  input logic              wrEn,
  input logic [DATA_W-1:0] wrData,
  input logic [6:0]        physAddr,
  input logic              isSfr,
  input logic              isRam,
  input logic              isNull,
  input logic              rdValid,
  input logic [DATA_W-1:0] rdData,
  input logic [6:0]        fsrPtr
);
  assert_common_alias_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!directAddr[4] && directAddr != 5'd0) |->
      (physAddr[6:4] == 3'b000 && physAddr[3:0] == directAddr[3:0]));

  assert_banked_direct_R2: assert property (@(posedge clk) disable iff (!rstN)
    directAddr[4] |->
      (physAddr[6:5] == fsrPtr[6:5] && physAddr[4] && physAddr[3:0] == directAddr[3:0]));

  assert_indirect_R3: assert property (@(posedge clk) disable iff (!rstN)
    (directAddr == 5'd0 && fsrPtr[4:0] != 5'd0) |->
      (physAddr[4:0] == fsrPtr[4:0]));

  assert_null_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && isNull) |=> (rdData == '0));

  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(isSfr && isRam));

  assert_rd_latency_R6: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |=> rdValid);

  assert_rd_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> !rdValid);

  assert_fsr_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !isNull && physAddr == 7'h04) |=> (fsrPtr == $past(wrData[6:0])));

  assert_sfr_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && isSfr && physAddr != 7'h04) |=> (rdData == '0));
endmodule

bind regfile_bank_mapper regmap_checker #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .directAddr(directAddr),
  .rdEn      (rdEn),
  .wrEn      (wrEn),
  .wrData    (wrData),
  .physAddr  (physAddr),
  .isSfr     (isSfr),
  .isRam     (isRam),
  .isNull    (isNull),
  .rdValid   (rdValid),
  .rdData    (rdData),
  .fsrPtr    (fsrPtr)
);

// File: tb/regfile_bank_mapper_tb_top.sv
`timescale 1ns/1ps
module regfile_bank_mapper_tb_top;
  localparam int NB = 3;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [4:0] directAddr = '0;
  logic       rdEn = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [6:0] physAddr;
  logic       isSfr, isRam, isNull, rdValid;
  logic [7:0] rdData;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] memM [128];
  logic [7:0] fsrM = 8'h00;
  logic [7:0] expQ [$];
  string      tagQ [$];

  always #2.5 clk = ~clk;

  regfile_bank_mapper #(.NUM_BANKS(NB), .DATA_W(8)) dut_i (
    .clk(clk), .rstN(rstN), .directAddr(directAddr), .rdEn(rdEn), .wrEn(wrEn),
    .wrData(wrData), .physAddr(physAddr), .isSfr(isSfr), .isRam(isRam),
    .isNull(isNull), .rdValid(rdValid), .rdData(rdData)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mapModel(input logic [4:0] da, input logic [7:0] f,
                          output logic [6:0] pa, output logic sfr, output logic ram,
                          output logic nul);
    logic [4:0] w;
    w   = (da == 5'd0) ? f[4:0] : da;
    nul = (da == 5'd0) && (f[4:0] == 5'd0);
    pa  = w[4] ? {f[6:5], 1'b1, w[3:0]} : {3'b000, w[3:0]};
    sfr = !w[4] && !w[3];
    ram = !sfr && (!w[4] || int'(f[6:5]) < NB);
  endtask

  task automatic access(input logic [4:0] da, input bit doRd, input bit doWr,
                        input logic [7:0] data, input string tag);
    logic [6:0] pa;
    logic sfr, ram, nul;
    logic [7:0] e;
    @(negedge clk);
    directAddr = da; rdEn = doRd; wrEn = doWr; wrData = data;
    #1;
    mapModel(da, fsrM, pa, sfr, ram, nul);
    chk({tag, " physAddr"}, {1'b0, physAddr}, {1'b0, pa});
    chk("R5 flags", {5'b0, isSfr, isRam, isNull}, {5'b0, sfr, ram, nul});
    if (doRd) begin
      if (nul)          e = 8'h00;
      else if (pa == 7'h04) e = fsrM;
      else if (ram)     e = memM[pa];
      else              e = 8'h00;
      expQ.push_back(e);
      tagQ.push_back(tag);
    end
    if (doWr && !nul) begin
      if (pa == 7'h04) fsrM = data;
      else if (ram)    memM[pa] = data;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    rdEn = 1'b0; wrEn = 1'b0;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && rdValid) begin
        if (expQ.size() == 0) begin
          checks++; failures++;
          $display("FAIL R6 unexpected rdValid actual=1 expected=0");
        end else begin
          chk(tagQ.pop_front(), rdData, expQ.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) memM[i] = 8'h00;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R11 rdValid after reset", {7'b0, rdValid}, 8'h00);
    access(5'h04, 1, 0, 8'h00, "R7 ptr reset");
    access(5'h0A, 1, 0, 8'h00, "R11 ram reset");
    access(5'h1F, 1, 0, 8'h00, "R11 banked reset");
    idle();
    chk("R6 rdValid drops", {7'b0, rdValid}, 8'h01);
    @(negedge clk);
    chk("R6 rdValid idle", {7'b0, rdValid}, 8'h00);

    // R2 banked direct, R1 common aliasing
    access(5'h04, 0, 1, 8'h20, "R7 ptr write bank1");
    access(5'h15, 0, 1, 8'hA1, "R2 write bank1");
    access(5'h0B, 0, 1, 8'hB2, "R1 write common");
    access(5'h04, 0, 1, 8'h00, "R7 ptr write bank0");
    access(5'h15, 0, 1, 8'hC3, "R2 write bank0");
    access(5'h15, 1, 0, 8'h00, "R2 read bank0");
    access(5'h0B, 1, 0, 8'h00, "R1 read common bank0");
    access(5'h04, 0, 1, 8'h40, "R7 ptr write bank2");
    access(5'h0B, 1, 0, 8'h00, "R1 read common bank2");
    access(5'h15, 1, 0, 8'h00, "R2 read bank2 empty");
    access(5'h04, 0, 1, 8'h20, "R7 ptr write bank1");
    access(5'h15, 1, 0, 8'h00, "R2 read bank1");

    // R3 indirect and pointer bit 7
    access(5'h04, 0, 1, 8'h35, "R7 ptr to 0x35");
    access(5'h00, 1, 0, 8'h00, "R3 indirect read");
    access(5'h04, 0, 1, 8'hB5, "R3 ptr bit7 set");
    access(5'h00, 1, 0, 8'h00, "R3 bit7 ignored");
    access(5'h00, 0, 1, 8'h5D, "R3 indirect write");
    access(5'h04, 0, 1, 8'h20, "R7 ptr bank1");
    access(5'h15, 1, 0, 8'h00, "R3 indirect write landed");
    access(5'h04, 0, 1, 8'h0C, "R7 ptr to common 0x0C");
    access(5'h00, 0, 1, 8'h6E, "R3 indirect common write");
    access(5'h0C, 1, 0, 8'h00, "R3 common via direct");

    // R4 null redirect
    access(5'h04, 0, 1, 8'h40, "R7 ptr null bank2");
    access(5'h00, 1, 0, 8'h00, "R4 null read");
    access(5'h00, 0, 1, 8'h77, "R4 null write");
    access(5'h04, 1, 0, 8'h00, "R4 ptr unchanged");
    access(5'h0C, 1, 0, 8'h00, "R4 ram unchanged");

    // R9 unimplemented bank 3
    access(5'h04, 0, 1, 8'h60, "R7 ptr bank3");
    access(5'h12, 0, 1, 8'h99, "R9 write dropped");
    access(5'h12, 1, 0, 8'h00, "R9 read zero");
    access(5'h04, 0, 1, 8'h72, "R7 ptr bank3 entry 0x12");
    access(5'h00, 1, 0, 8'h00, "R9 indirect read zero");
    access(5'h04, 0, 1, 8'h00, "R7 ptr bank0");
    access(5'h12, 1, 0, 8'h00, "R9 no alias bank0");

    // R8 other special locations
    access(5'h05, 0, 1, 8'h55, "R8 sfr write");
    access(5'h05, 1, 0, 8'h00, "R8 sfr read");
    access(5'h02, 0, 1, 8'hAA, "R8 sfr write 2");
    access(5'h02, 1, 0, 8'h00, "R8 sfr read 2");
    access(5'h0B, 1, 0, 8'h00, "R8 ram untouched");

    // R7 pointer via redirect
    access(5'h04, 0, 1, 8'h04, "R7 ptr self");
    access(5'h00, 0, 1, 8'h2C, "R7 indirect ptr write");
    access(5'h04, 1, 0, 8'h00, "R7 ptr readback");

    // R10 read during write
    access(5'h0B, 1, 1, 8'hE7, "R10 rd old value");
    access(5'h0B, 1, 0, 8'h00, "R10 new value");

    // R6 fill and read back every implemented bank
    for (int b = 0; b < NB; b++) begin
      access(5'h04, 0, 1, 8'(b << 5), "R7 ptr bank sweep");
      for (int a = 16; a < 32; a++)
        access(5'(a), 0, 1, 8'(b * 37 + a * 5 + 1), "R6 sweep write");
    end
    for (int b = 0; b < NB; b++) begin
      access(5'h04, 0, 1, 8'(b << 5), "R7 ptr bank sweep");
      for (int a = 16; a < 32; a++)
        access(5'(a), 1, 0, 8'h00, "R6 sweep read");
    end
    idle();
    repeat (3) @(negedge clk);
    chk("R6 queue drained", 8'(expQ.size()), 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule